// File: doc/BRIEF.md
# Dual-Channel Serial DAC Input Register

This block is the digital front end of a two-channel 12-bit converter with a serial interface. A host sends frames over a serial clock, a data line and an active-low chip select. Each frame is 14 bits long: a 2-bit channel address followed by a 12-bit code. A separate active-low load strobe moves the received word into one or both channel output registers. The two 12-bit outputs are the codes that would drive the converters. They use straight binary coding: 000h is zero scale, 800h is midscale and FFFh is full scale.

The output registers act as level-sensitive latches. While the load strobe is high they hold their values, so a new frame can be shifted in without disturbing them. While the strobe is low, the channels selected by the address follow the shift register as it fills. All serial inputs are oversampled in a faster system clock domain. They pass through two-flop synchronizers, and the serial clock is edge-detected, so the whole design stays synchronous.

Top module: `dual_dac_frontend`

## Requirements
- R1: A frame is shifted in with address bit A1 first, then A0, then the 12 data bits MSB first. After 14 shifts, the upper two bits of the 14-bit shift register hold {A1,A0} and the lower 12 bits hold the data word.
- R2: Each rising edge of the serial clock shifts in exactly one data bit. A falling edge shifts nothing.
- R3: While chip select is high, serial clock edges leave the shift register unchanged.
- R4: While the load strobe is low, the selected output registers track the shift register's data field on every shift. This happens whatever the state of chip select or the serial clock.
- R5: While the load strobe is high, both output codes hold their values.
- R6: Address decode during a load works as follows. {A1,A0} = 2'b00 or 2'b01 loads both channels. 2'b10 loads channel A only. 2'b11 loads channel B only. The channel that is not selected keeps its value.
- R7: Reset clears the shift register and both output codes to 000h.
- R8: When the load strobe goes low, the output codes show the loaded word within 4 system clock cycles.
- R9: Output codes equal the received data bits unchanged, in straight binary. Zero scale, midscale and full scale come out as 000h, 800h and FFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock; data is taken on its rising edge |
| cs_n_i | input | 1 | Active-low chip select that enables shifting |
| sdata_i | input | 1 | Serial data input |
| ld_n_i | input | 1 | Active-low load strobe; the output latches are transparent while it is low |
| code_a_o | output | 12 | Channel A output code |
| code_b_o | output | 12 | Channel B output code |

## Verification
Shifting and loading can occur in the same cycle when the load strobe is held low while a frame is clocked in. The bench provokes this by keeping the strobe low for a whole frame. After every serial bit it compares both outputs against a bench-side model of the shift register. The model re-decodes the address each time, because the address field itself moves as the bits arrive. The channel that the shifting address selects must change bit by bit, and the other channel must hold.

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend #(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              sdata_i,
  input  logic              ld_n_i,
  output logic [DATA_W-1:0] code_a_o,
  output logic [DATA_W-1:0] code_b_o
);
  localparam int ADDR_W  = 2;
  localparam int FRAME_W = DATA_W + ADDR_W;

  logic [SYNC_STAGES-1:0] sclk_sy, cs_sy, sd_sy, ld_sy;
  logic                   sclk_d;
  logic [FRAME_W-1:0]     shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      cs_sy   <= '1;
      sd_sy   <= '0;
      ld_sy   <= '1;
      sclk_d  <= 1'b0;
    end else begin
      sclk_sy <= {sclk_sy[SYNC_STAGES-2:0], sclk_i};
      cs_sy   <= {cs_sy[SYNC_STAGES-2:0], cs_n_i};
      sd_sy   <= {sd_sy[SYNC_STAGES-2:0], sdata_i};
      ld_sy   <= {ld_sy[SYNC_STAGES-2:0], ld_n_i};
      sclk_d  <= sclk_sy[SYNC_STAGES-1];
    end
  end

  wire sclk_q    = sclk_sy[SYNC_STAGES-1];
  wire cs_q      = cs_sy[SYNC_STAGES-1];
  wire sd_q      = sd_sy[SYNC_STAGES-1];
  wire ld_q      = ld_sy[SYNC_STAGES-1];
  wire sclk_rise = sclk_q & ~sclk_d;
  wire shift_en  = sclk_rise & ~cs_q;

  wire [ADDR_W-1:0] addr = shift_q[FRAME_W-1 -: ADDR_W];
  wire [DATA_W-1:0] word = shift_q[DATA_W-1:0];
  wire upd_a = ~ld_q & (~addr[1] | ~addr[0]);
  wire upd_b = ~ld_q & (~addr[1] |  addr[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shift_q <= '0;
    else if (shift_en) shift_q <= {shift_q[FRAME_W-2:0], sd_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_a_o <= '0;
      code_b_o <= '0;
    end else begin
      if (upd_a) code_a_o <= word;
      if (upd_b) code_b_o <= word;
    end
  end
endmodule

// File: rtl/dual_dac_frontend_sva.sv
module dual_dac_frontend_sva #(
  parameter int DATA_W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                shift_en,
  input logic                cs_q,
  input logic                ld_q,
  input logic                sd_q,
  input logic [DATA_W+1:0]   shift_q,
  input logic [DATA_W-1:0]   code_a_o,
  input logic [DATA_W-1:0]   code_b_o
);
  assert_shift_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> shift_q == {$past(shift_q[DATA_W:0]), $past(sd_q)});

  assert_cs_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |=> $stable(shift_q));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_q |=> ($stable(code_a_o) && $stable(code_b_o)));

  assert_load_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_q && shift_q[DATA_W+1 -: 2] == 2'b10) |=>
      (code_a_o == $past(shift_q[DATA_W-1:0]) && $stable(code_b_o)));

  assert_load_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_q && shift_q[DATA_W+1 -: 2] == 2'b11) |=>
      (code_b_o == $past(shift_q[DATA_W-1:0]) && $stable(code_a_o)));

  assert_load_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_q && !shift_q[DATA_W+1]) |=>
      (code_a_o == $past(shift_q[DATA_W-1:0]) && code_b_o == $past(shift_q[DATA_W-1:0])));
endmodule

bind dual_dac_frontend dual_dac_frontend_sva #(.DATA_W(DATA_W)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .shift_en (shift_en),
  .cs_q     (cs_q),
  .ld_q     (ld_q),
  .sd_q     (sd_q),
  .shift_q  (shift_q),
  .code_a_o (code_a_o),
  .code_b_o (code_b_o)
);

// File: tb/tb_dual_dac_frontend.sv
module tb_dual_dac_frontend;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, cs_n = 1'b1, sdata = 1'b0, ld_n = 1'b1;
  logic [11:0] code_a, code_b;
  logic [13:0] m_shift = '0;
  logic [11:0] exp_a = '0, exp_b = '0;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  dual_dac_frontend dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n),
    .sdata_i(sdata), .ld_n_i(ld_n), .code_a_o(code_a), .code_b_o(code_b)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req);
    n_chk++;
    if (code_a !== exp_a || code_b !== exp_b) begin
      n_bad++;
      $display("FAIL %s: a=%h b=%h expected a=%h b=%h", req, code_a, code_b, exp_a, exp_b);
    end
  endtask

  task automatic model_latch();
    if (!ld_n) begin
      if (!m_shift[13] || !m_shift[12]) exp_a = m_shift[11:0];
      if (!m_shift[13] ||  m_shift[12]) exp_b = m_shift[11:0];
    end
  endtask

  task automatic send_bit(input logic b);
    sdata = b;
    tick(HALF);
    sclk = 1'b1;
    if (!cs_n) m_shift = {m_shift[12:0], b};
    tick(HALF);
    sclk = 1'b0;
    model_latch();
  endtask

  task automatic send_frame(input logic [1:0] addr, input logic [11:0] data, input logic sel);
    logic [13:0] f;
    f = {addr, data};
    cs_n = ~sel;
    tick(HALF);
    for (int i = 13; i >= 0; i--) send_bit(f[i]);
    cs_n = 1'b1;
    tick(HALF);
  endtask

  task automatic pulse_load(input string req);
    ld_n = 1'b0;
    model_latch();
    tick(4);
    check({req, " R8 latency"});
    tick(HALF);
    ld_n = 1'b1;
    tick(HALF);
    check(req);
  endtask

  task automatic t_reset();
    check("R7 reset outputs");
    pulse_load("R7 reset shift register");
  endtask

  task automatic t_double_buffer();
    send_frame(2'b10, 12'hABC, 1'b1);
    check("R5 hold while strobe high");
    pulse_load("R6 R1 load channel A");
  endtask

  task automatic t_addr_b();
    send_frame(2'b11, 12'h123, 1'b1);
    check("R5 hold while strobe high");
    pulse_load("R6 load channel B");
  endtask

  task automatic t_both_scales();
    send_frame(2'b01, 12'hFFF, 1'b1);
    pulse_load("R9 R6 full scale both");
    send_frame(2'b00, 12'h800, 1'b1);
    pulse_load("R9 R6 midscale both");
    send_frame(2'b00, 12'h000, 1'b1);
    pulse_load("R9 zero scale both");
  endtask

  task automatic t_cs_ignore();
    send_frame(2'b10, 12'h7FF, 1'b1);
    pulse_load("R6 load A before deselect");
    send_frame(2'b11, 12'h000, 1'b0);
    pulse_load("R3 R2 deselected clocks ignored");
  endtask

  task automatic t_transparent();
    ld_n = 1'b0;
    model_latch();
    tick(HALF);
    cs_n = 1'b0;
    tick(HALF);
    for (int i = 13; i >= 0; i--) begin
      send_bit(((14'h2A5A) >> i) & 1'b1);
      tick(HALF);
      check("R4 transparent bit by bit");
    end
    cs_n = 1'b1;
    ld_n = 1'b1;
    tick(HALF);
    send_frame(2'b00, 12'h3C3, 1'b1);
    check("R5 hold after transparency");
  endtask

  initial begin
    fork
      begin
        tick(3);
        rst_n = 1'b1;
        tick(3);
        t_reset();
        t_double_buffer();
        t_addr_b();
        t_both_scales();
        t_cs_ignore();
        t_transparent();
        done = 1'b1;
      end
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          n_chk++;
          n_bad++;
          $display("FAIL watchdog: run did not complete");
        end
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule